// File: doc/BRIEF.md
# Serial Port Interrupt Register Bank

This block holds the interrupt registers of a serial port with four interrupt sources: transmit watermark, receive watermark, transmit empty and receive overflow. Event generators elsewhere in the port send single-cycle pulses on `hw_event`. Each pulse latches a sticky pending bit. Software reaches the bank over a simple 32-bit register bus that uses byte addresses on word boundaries. Through that bus it reads the pending bits, clears them by writing ones, enables or masks each source, and forces pending bits through a test register that cannot be read back.

Each source drives its own interrupt line, and the four lines are never combined. A line is high when its pending bit and its enable bit are both set. The lines come from flip-flops that load the same next-state values as the pending and enable registers, so a line changes on the same clock edge as the register bits it depends on. Read data is registered and appears one cycle after the read strobe.

Top module: `sio_irq_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the pending bits, the enable bits, `irq_o` and `bus_rdata` are all zero.
- R2: Pending bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty and bit 3 is receive overflow. A high `hw_event[i]` at a clock edge sets pending bit i at that edge.
- R3: `bus_addr[5:2]` selects the register and `bus_addr[1:0]` is ignored. Word 0 (byte 0x00) is pending, word 1 (0x04) is enable and word 2 (0x08) is test. A write to any other word changes nothing, and a read of any other word returns zero.
- R4: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to the test register ORs the low four bits of the written value into the pending bits.
- R6: `irq_o[i]` is high exactly when pending bit i and enable bit i are both set. It changes on the same clock edge as those bits.
- R7: A read of the test register returns zero.
- R8: When `hw_event[i]` and a write of 1 to pending bit i arrive in the same cycle, bit i ends up set.
- R9: Bits 31:4 of all three registers read as zero, and writes to them have no effect.
- R10: A pending bit stays set until software clears it, whatever the inputs do in the meantime.
- R11: A read presents data on `bus_rdata` in the cycle after `bus_rd_en`, showing register contents as they were before that clock edge. The value then holds until the next read.
- R12: A write to the enable register loads the low four bits of the written value as the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_event | input | 4 | Set pulses from the event generators |
| irq_o | output | 4 | One interrupt line per source |

## Verification
Every result is due one clock edge after its cause. A pulse or a write applied before edge N shows up in the pending bits and on `irq_o` right after edge N. A read strobed before edge N presents its data right after edge N, and that data reflects the registers as they were before edge N. The bench drives each stimulus at a falling edge, moves its model forward by exactly one rising edge, and compares the outputs at the following falling edge. Reads are checked against the model values captured before that model update.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int unsigned WORD_PENDING = 0;
  localparam int unsigned WORD_ENABLE  = 1;
  localparam int unsigned WORD_TEST    = 2;

  typedef enum logic [1:0] {
    SEL_PENDING = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_TEST    = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sio_irq_decode.sv
module sio_irq_decode
  import sio_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_pending,
  output logic              wr_enable,
  output logic              wr_test,
  output reg_sel_e          sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    case (word)
      WORD_W'(WORD_PENDING): sel = SEL_PENDING;
      WORD_W'(WORD_ENABLE):  sel = SEL_ENABLE;
      WORD_W'(WORD_TEST):    sel = SEL_TEST;
      default:               sel = SEL_NONE;
    endcase
  end

  assign wr_pending = wr_en && (sel == SEL_PENDING);
  assign wr_enable  = wr_en && (sel == SEL_ENABLE);
  assign wr_test    = wr_en && (sel == SEL_TEST);
endmodule

// File: rtl/sio_irq_cell.sv
module sio_irq_cell (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic sw_clr,
  input  logic sw_force,
  input  logic en_load,
  input  logic en_val,
  output logic pend_q,
  output logic en_q,
  output logic irq_q
);
  logic pend_d;
  logic en_d;

  // a hardware set outranks a software clear in the same cycle
  assign pend_d = (pend_q && !sw_clr) || hw_set || sw_force;
  assign en_d   = en_load ? en_val : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= pend_d && en_d;
    end
  end
endmodule

// File: rtl/sio_irq_rdmux.sv
module sio_irq_rdmux
  import sio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  reg_sel_e           sel,
  input  logic [NUM_SRC-1:0] pend_vec,
  input  logic [NUM_SRC-1:0] en_vec,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    case (sel)
      SEL_PENDING: word_d[NUM_SRC-1:0] = pend_vec;
      SEL_ENABLE:  word_d[NUM_SRC-1:0] = en_vec;
      default:     word_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= word_d;
    end
  end
endmodule

// File: rtl/sio_irq_bank.sv
module sio_irq_bank
  import sio_irq_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] hw_event,
  output logic [NUM_SRC-1:0] irq_o
);
  logic     wr_pending;
  logic     wr_enable;
  logic     wr_test;
  reg_sel_e sel;

  logic [NUM_SRC-1:0] pend_vec;
  logic [NUM_SRC-1:0] en_vec;

  sio_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en      (bus_wr_en),
    .addr       (bus_addr),
    .wr_pending (wr_pending),
    .wr_enable  (wr_enable),
    .wr_test    (wr_test),
    .sel        (sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    sio_irq_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .hw_set   (hw_event[i]),
      .sw_clr   (wr_pending && bus_wdata[i]),
      .sw_force (wr_test && bus_wdata[i]),
      .en_load  (wr_enable),
      .en_val   (bus_wdata[i]),
      .pend_q   (pend_vec[i]),
      .en_q     (en_vec[i]),
      .irq_q    (irq_o[i])
    );
  end

  sio_irq_rdmux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rdmux (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd_en),
    .sel      (sel),
    .pend_vec (pend_vec),
    .en_vec   (en_vec),
    .rdata_q  (bus_rdata)
  );
endmodule

// File: rtl/sio_irq_bank_chk.sv
module sio_irq_bank_chk #(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic [DATA_W-1:0]  rdata,
  input logic [NUM_SRC-1:0] hw_event,
  input logic [NUM_SRC-1:0] irq,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] enable
);
  logic wr_p;
  logic wr_t;
  assign wr_p = wr_en && (addr[ADDR_W-1:2] == '0);
  assign wr_t = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(2));

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq == '0) && (pend == '0) && (enable == '0) && (rdata == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
      hw_event[i] |=> pend[i]);
    a_r4_w1c: assert property (@(posedge clk) disable iff (rst)
      (wr_p && wdata[i] && !hw_event[i] && !wr_t) |=> !pend[i]);
    a_r5_test_sets: assert property (@(posedge clk) disable iff (rst)
      (wr_t && wdata[i]) |=> pend[i]);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
      (hw_event[i] && wr_p && wdata[i]) |=> pend[i]);
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !(wr_p && wdata[i])) |=> pend[i]);
    a_r6_line_needs_both: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> (pend[i] && enable[i]));
    a_r6_line_follows: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && enable[i]) |-> irq[i]);
  end
endmodule

bind sio_irq_bank sio_irq_bank_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (bus_wr_en),
  .addr     (bus_addr),
  .wdata    (bus_wdata),
  .rdata    (bus_rdata),
  .hw_event (hw_event),
  .irq      (irq_o),
  .pend     (pend_vec),
  .enable   (en_vec)
);

// File: tb/sio_irq_bank_bench.sv
module sio_irq_bank_bench;
  localparam int NS = 4;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NS-1:0] hw_event = '0;
  logic [NS-1:0] irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [NS-1:0] m_pend = '0;
  logic [NS-1:0] m_en   = '0;
  logic [DW-1:0] m_rdata = '0;

  always #4 clk = ~clk;

  sio_irq_bank #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) u_sio_irq_bank (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_event(hw_event), .irq_o(irq_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a,
                                             input logic [NS-1:0] p,
                                             input logic [NS-1:0] e);
    logic [DW-1:0] r;
    r = '0;
    case (a[AW-1:2])
      4'd0: r[NS-1:0] = p;
      4'd1: r[NS-1:0] = e;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, advance model one rising edge, check at next falling edge
  task automatic step(input logic wr, input logic rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [NS-1:0] ev,
                      input string req);
    logic [NS-1:0] clr;
    logic [NS-1:0] frc;
    bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = wd; hw_event = ev;
    @(posedge clk);
    if (rd) m_rdata = exp_read(a, m_pend, m_en);
    clr = (wr && a[AW-1:2] == 4'd0) ? wd[NS-1:0] : '0;
    frc = (wr && a[AW-1:2] == 4'd2) ? wd[NS-1:0] : '0;
    m_pend = (m_pend & ~clr) | ev | frc;
    if (wr && a[AW-1:2] == 4'd1) m_en = wd[NS-1:0];
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; hw_event = '0;
    chk({req, " R6 irq lines"}, DW'(irq_o), DW'(m_pend & m_en));
    chk({req, " R11 read data"}, bus_rdata, m_rdata);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", DW'(irq_o), '0);
    chk("R1 rdata in reset", bus_rdata, '0);
    rst = 1'b0;
    chk("R1 irq after reset", DW'(irq_o), '0);
    step(0, 1, 6'h00, '0, '0, "R1 pending reads zero");
    step(0, 1, 6'h04, '0, '0, "R1 enable reads zero");

    // R9 upper bits, R5 force, R12 enable load
    step(1, 0, 6'h08, 32'hFFFF_FFFF, '0, "R5 force all");
    step(0, 1, 6'h00, '0, '0, "R9 pending upper zero");
    step(1, 0, 6'h04, 32'hFFFF_FFF0, '0, "R9 enable upper ignored");
    step(0, 1, 6'h04, '0, '0, "R12 enable reads zero");
    step(1, 0, 6'h04, 32'h0000_0005, '0, "R12 enable 0101");
    step(0, 1, 6'h08, '0, '0, "R7 test reads zero");
    // R4 partial clear
    step(1, 0, 6'h00, 32'h0000_0003, '0, "R4 clear bits 1:0");
    step(0, 1, 6'h00, '0, '0, "R4 pending after clear");
    // R8 set beats clear on bit 3
    step(1, 0, 6'h00, 32'h0000_0008, 4'b1000, "R8 set with clear");
    step(0, 1, 6'h00, '0, '0, "R8 bit 3 kept");
    // R3 unmapped word and low address bits
    step(1, 0, 6'h0C, 32'hFFFF_FFFF, '0, "R3 unmapped write");
    step(0, 1, 6'h0C, '0, '0, "R3 unmapped read");
    step(0, 1, 6'h03, '0, '0, "R3 low bits ignored");
    // R10 sticky over idle cycles
    repeat (5) step(0, 0, 6'h00, '0, '0, "R10 idle");
    step(0, 1, 6'h00, '0, '0, "R10 pending held");
    // R2 each source pulse
    step(1, 0, 6'h00, 32'hF, '0, "R4 clear all");
    step(1, 0, 6'h04, 32'hF, '0, "R12 enable all");
    for (int i = 0; i < NS; i++) begin
      step(0, 0, 6'h00, '0, NS'(1) << i, "R2 single event");
      step(0, 1, 6'h00, '0, '0, "R2 bit mapping");
    end

    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      int pick;
      pick = $urandom_range(0, 4);
      a = (pick == 3) ? 6'h0C : (pick == 4) ? 6'h3C : AW'(pick * 4);
      a[1:0] = 2'($urandom_range(0, 3));
      step($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a,
           $urandom(), ($urandom_range(0, 3) == 0) ? NS'($urandom()) : '0,
           "R2 R4 R5 R12 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule